// File: doc/BRIEF.md
# Page Write Load Controller

This block sits between a host's asynchronous-style write strobes and the programming engine of a nonvolatile array. The host writes bytes the way it would write a static RAM: it lowers chip-enable and write-enable with output-enable high. The controller gathers those bytes into a page buffer of `2**OFS_W` entries, each with its own valid flag. When the host stops writing for a set number of clock cycles, the controller closes the page. It then raises a program request that carries the page number, the byte mask and the buffered bytes, and holds them until the array reports completion.

The strobes pass through a minimum-width filter. Writes are blocked while output-enable is low, while the supply flag is low, and for a power-on delay after that flag rises. All strobe, address and data inputs are taken as synchronous to `clk`.

The sequencer has three states. `ST_IDLE` waits for the first byte, and the transition *first byte* moves it to `ST_LOAD`. In `ST_LOAD` the transition *same-page byte* stays in `ST_LOAD` and restarts the window. Two transitions leave `ST_LOAD` for `ST_PROG`: *window expiry* and *foreign-page byte*. In `ST_PROG` the transition *program done* returns to `ST_IDLE`.

Top module: `pwl_load_ctrl`

## Requirements
- R1: A byte is stored only by a write pulse. Such a pulse needs both `ce_n` and `we_n` low, as seen through the filter, with `oe_n` high and power ready. The byte is committed on the clock edge where the first of `ce_n`/`we_n` is seen high again.
- R2: The address is sampled on the edge where the pulse becomes active, which is after the later of the two strobe falls. `addr[16:7]` is the page number and `addr[6:0]` is the byte offset.
- R3: The stored data is the value of `din` on the last clock edge before the first strobe rise. Changes to `din` after that edge have no effect.
- R4: A strobe held low for at most `GLITCH_CYC` sampled edges never counts as asserted. One held low for `GLITCH_CYC+1` or more edges does count.
- R5: No byte is stored while `oe_n` is low, while `pwr_ok` is low, or within `POR_CYC` edges after `pwr_ok` rises.
- R6: Bytes may arrive at any offsets in any order, and a later write to the same offset replaces the earlier one. Bit i of `prog_mask` is set exactly for the offsets written, and byte i of `prog_data` is `prog_data[8*i+7:8*i]`.
- R7: `busy` and `prog_req` rise exactly `LOAD_WIN` clock edges after the edge that committed the last byte, provided no further byte arrives in that time.
- R8: A byte whose page differs from the open page closes the page at once: `busy` is high after that commit edge. That byte is discarded and does not open a new page.
- R9: While `prog_req` is high, `prog_page`, `prog_mask` and `prog_data` hold steady and new writes are ignored. `prog_req` stays high until `prog_done` is sampled high, after which `busy` is low.
- R10: After reset, `busy` and `prog_req` are low and `prog_mask` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip-enable strobe, active low |
| we_n | input | 1 | Write-enable strobe, active low |
| oe_n | input | 1 | Output-enable, active low; low blocks writes |
| addr | input | 17 | Byte address: page in [16:7], offset in [6:0] |
| din | input | 8 | Write data byte |
| pwr_ok | input | 1 | Supply above threshold |
| prog_done | input | 1 | Array finished programming |
| busy | output | 1 | Page closed, programming in progress |
| prog_req | output | 1 | Program request to the array |
| prog_page | output | 10 | Page number to program |
| prog_mask | output | 128 | One bit per loaded byte |
| prog_data | output | 1024 | Buffered page bytes |

## Verification
The assertions assume that `prog_done` arrives only as a reply to `prog_req`. They also assume that every strobe and data input changes away from the rising clock edge. The bench drives all inputs at the falling edge. It raises `prog_done` only after it has seen `busy`, and only for a single cycle. Random pages, offsets, data bytes and choices of strobe order are drawn with a fixed seed. Each page stays on one page number, except in the directed case that checks the foreign-page rule.

// File: rtl/pwl_pkg.sv
package pwl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } pwl_state_e;
endpackage

// File: rtl/pwl_glitch_filter.sv
// Reports a strobe as asserted only once it has been low for more than
// MIN_CYC sampled edges; release is seen at once.
module pwl_glitch_filter #(
    parameter int MIN_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic asserted
);
    localparam int CW = $clog2(MIN_CYC + 1);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (strobe_n) begin
            low_cnt <= '0;
        end else if (low_cnt != CW'(MIN_CYC)) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign asserted = !strobe_n && (low_cnt == CW'(MIN_CYC));
endmodule

// File: rtl/pwl_power_gate.sv
// Holds writes off until the supply flag has been high for POR_CYC edges.
module pwl_power_gate #(
    parameter int POR_CYC = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    output logic ready
);
    localparam int PW = $clog2(POR_CYC + 1);

    logic [PW-1:0] up_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_cnt <= '0;
        end else if (!pwr_ok) begin
            up_cnt <= '0;
        end else if (up_cnt != PW'(POR_CYC)) begin
            up_cnt <= up_cnt + 1'b1;
        end
    end

    assign ready = pwr_ok && (up_cnt == PW'(POR_CYC));
endmodule

// File: rtl/pwl_page_buf.sv
// Page buffer: one register per byte and a valid flag per byte.
module pwl_page_buf #(
    parameter int OFS_W  = 7,
    parameter int DATA_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic                         start,
    input  logic                         clr,
    input  logic [OFS_W-1:0]             idx,
    input  logic [DATA_W-1:0]            wdata,
    output logic [(1<<OFS_W)-1:0]        mask,
    output logic [(1<<OFS_W)*DATA_W-1:0] data
);
    localparam int N = 1 << OFS_W;

    logic [N-1:0] sel;

    always_comb begin
        sel      = '0;
        sel[idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (clr) begin
            mask <= '0;
        end else if (wr_en) begin
            mask <= (start ? '0 : mask) | sel;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data[g*DATA_W +: DATA_W] <= '0;
            end else if (wr_en && sel[g]) begin
                data[g*DATA_W +: DATA_W] <= wdata;
            end
        end
    end
endmodule

// File: rtl/pwl_load_ctrl.sv
module pwl_load_ctrl
    import pwl_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int OFS_W      = 7,
    parameter int DATA_W     = 8,
    parameter int LOAD_WIN   = 7500,
    parameter int GLITCH_CYC = 1,
    parameter int POR_CYC    = 250000
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                ce_n,
    input  logic                                we_n,
    input  logic                                oe_n,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [DATA_W-1:0]                   din,
    input  logic                                pwr_ok,
    input  logic                                prog_done,
    output logic                                busy,
    output logic                                prog_req,
    output logic [ADDR_W-OFS_W-1:0]             prog_page,
    output logic [(1<<OFS_W)-1:0]               prog_mask,
    output logic [(1<<OFS_W)*DATA_W-1:0]        prog_data
);
    localparam int PAGE_W = ADDR_W - OFS_W;
    localparam int TMR_W  = $clog2(LOAD_WIN + 1);

    pwl_state_e state, state_nx;

    logic ce_on, we_on, pwr_rdy;
    logic wr_act, act_q, released, commit;
    logic [ADDR_W-1:0] addr_lat;
    logic [DATA_W-1:0] data_hold;
    logic [PAGE_W-1:0] cur_page;
    logic [TMR_W-1:0]  win_tmr;
    logic same_page, win_end;
    logic buf_wr, buf_start, buf_clr;

    pwl_glitch_filter #(.MIN_CYC(GLITCH_CYC)) u_ce_flt (
        .clk(clk), .rst_n(rst_n), .strobe_n(ce_n), .asserted(ce_on)
    );

    pwl_glitch_filter #(.MIN_CYC(GLITCH_CYC)) u_we_flt (
        .clk(clk), .rst_n(rst_n), .strobe_n(we_n), .asserted(we_on)
    );

    pwl_power_gate #(.POR_CYC(POR_CYC)) u_pwr (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .ready(pwr_rdy)
    );

    // Write pulse qualification and edge-specific capture
    assign wr_act   = ce_on && we_on && oe_n && pwr_rdy;
    assign released = ce_n || we_n;
    assign commit   = act_q && released && oe_n && pwr_rdy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q     <= 1'b0;
            addr_lat  <= '0;
            data_hold <= '0;
        end else begin
            act_q <= wr_act;
            if (wr_act && !act_q) addr_lat <= addr;
            if (wr_act) data_hold <= din;
        end
    end

    assign same_page = (addr_lat[ADDR_W-1:OFS_W] == cur_page);
    assign win_end   = (win_tmr == TMR_W'(LOAD_WIN - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (commit) state_nx = ST_LOAD;
            ST_LOAD: begin
                if (commit && !same_page)  state_nx = ST_PROG;
                else if (!commit && win_end) state_nx = ST_PROG;
            end
            ST_PROG: if (prog_done) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs and buffer controls
    always_comb begin
        busy      = 1'b0;
        buf_wr    = 1'b0;
        buf_start = 1'b0;
        buf_clr   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                buf_wr    = commit;
                buf_start = commit;
            end
            ST_LOAD: buf_wr = commit && same_page;
            ST_PROG: begin
                busy    = 1'b1;
                buf_clr = prog_done;
            end
            default: ;
        endcase
        prog_req = busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_page <= '0;
            win_tmr  <= '0;
        end else begin
            if (buf_start) cur_page <= addr_lat[ADDR_W-1:OFS_W];
            if (buf_wr)                win_tmr <= '0;
            else if (state == ST_LOAD) win_tmr <= win_tmr + 1'b1;
        end
    end

    pwl_page_buf #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(buf_wr), .start(buf_start), .clr(buf_clr),
        .idx(addr_lat[OFS_W-1:0]), .wdata(data_hold),
        .mask(prog_mask), .data(prog_data)
    );

    assign prog_page = cur_page;
endmodule

// File: rtl/pwl_load_ctrl_chk.sv
module pwl_load_ctrl_chk #(
    parameter int PAGE_W = 10,
    parameter int NB     = 128,
    parameter int DW     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              oe_n,
    input logic              pwr_ok,
    input logic              prog_done,
    input logic              busy,
    input logic              prog_req,
    input logic [PAGE_W-1:0] prog_page,
    input logic [NB-1:0]     prog_mask,
    input logic [NB*DW-1:0]  prog_data
);
    // R9: request held until done
    a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req && !prog_done |=> prog_req);

    // R9: program payload stable while requested
    a_r9_payload_stable: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req && !prog_done |=> $stable(prog_page) && $stable(prog_mask) && $stable(prog_data));

    // R6: a request always carries at least one byte
    a_r6_mask_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> prog_mask != '0);

    // R5: output-enable low stores nothing
    a_r5_oe_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n && !prog_done |=> $stable(prog_mask));

    // R5: supply low stores nothing
    a_r5_pwr_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok && !prog_done |=> $stable(prog_mask));

    // R9: done returns to idle
    a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req && prog_done |=> !busy);

    // R10: idle output pair agrees
    a_r10_busy_req: assert property (@(posedge clk) disable iff (!rst_n)
        busy == prog_req);
endmodule

bind pwl_load_ctrl pwl_load_ctrl_chk #(
    .PAGE_W(ADDR_W - OFS_W), .NB(1 << OFS_W), .DW(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .pwr_ok(pwr_ok),
    .prog_done(prog_done), .busy(busy), .prog_req(prog_req),
    .prog_page(prog_page), .prog_mask(prog_mask), .prog_data(prog_data)
);

// File: tb/pwl_load_ctrl_test.sv
`timescale 1ns/1ps
module pwl_load_ctrl_test;
    localparam int WIN = 40;
    localparam int GL  = 2;
    localparam int POR = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [16:0] addr = '0;
    logic [7:0]  din = '0;
    logic pwr_ok = 1'b1, prog_done = 1'b0;
    logic busy, prog_req;
    logic [9:0] prog_page;
    logic [127:0] prog_mask;
    logic [1023:0] prog_data;

    int n_chk = 0, n_bad = 0;
    logic [127:0] emask;
    logic [7:0]   edata [128];
    logic [9:0]   epage;

    always #10 clk = ~clk;

    pwl_load_ctrl #(.LOAD_WIN(WIN), .GLITCH_CYC(GL), .POR_CYC(POR)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .pwr_ok(pwr_ok), .prog_done(prog_done),
        .busy(busy), .prog_req(prog_req), .prog_page(prog_page),
        .prog_mask(prog_mask), .prog_data(prog_data)
    );

    function automatic logic [9:0] page_of(input logic [16:0] a);
        return a[16:7];
    endfunction

    function automatic logic [127:0] bit_of(input logic [16:0] a);
        logic [127:0] m = '0;
        m[a[6:0]] = 1'b1;
        return m;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // one write pulse; the other strobe falls first, so the controlling one falls last
    task automatic wr(input logic [16:0] a, input logic [7:0] d, input bit via_ce, input int len, input bit oe);
        @(negedge clk); addr = a; din = d; oe_n = oe;
        if (via_ce) we_n = 1'b0; else ce_n = 1'b0;
        @(negedge clk);
        if (via_ce) ce_n = 1'b0; else we_n = 1'b0;
        repeat (len) @(negedge clk);
        if (via_ce) ce_n = 1'b1; else we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic model_wr(input logic [16:0] a, input logic [7:0] d);
        if (emask == '0) epage = page_of(a);
        emask |= bit_of(a);
        edata[a[6:0]] = d;
    endtask

    task automatic check_payload(input string tag);
        check(prog_page == epage, tag, 128'(prog_page), 128'(epage));
        check(prog_mask == emask, tag, prog_mask, emask);
        for (int i = 0; i < 128; i++)
            if (emask[i])
                check(prog_data[8*i +: 8] == edata[i], tag, 128'(prog_data[8*i +: 8]), 128'(edata[i]));
    endtask

    task automatic finish_prog();
        @(negedge clk); prog_done = 1'b1;
        @(negedge clk); prog_done = 1'b0;
        check(busy == 1'b0, "R9 busy after done", 128'(busy), 128'd0);
        emask = '0;
    endtask

    // window must expire exactly WIN edges after the last commit
    task automatic window_check(input string tag);
        repeat (WIN - 1) @(negedge clk);
        check(busy == 1'b0, {tag, " R7 early"}, 128'(busy), 128'd0);
        @(negedge clk);
        check(busy == 1'b1 && prog_req == 1'b1, {tag, " R7 expiry"}, 128'(busy), 128'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [16:0] a;
        logic [7:0] d;
        void'($urandom(32'h5EED_0042));
        emask = '0;
        epage = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(!busy && !prog_req, "R10 reset flags", 128'({busy, prog_req}), 128'd0);
        check(prog_mask == '0, "R10 reset mask", prog_mask, 128'd0);
        rst_n = 1'b1;

        // R5: write inside power-on delay is ignored
        wr(17'h00105, 8'h11, 1'b0, 4, 1'b1);
        repeat (WIN + 5) @(negedge clk);
        check(busy == 1'b0, "R5 por write ignored", 128'(busy), 128'd0);

        // R4 + R5: glitch and oe-low writes ignored, then a good one
        wr(17'h00201, 8'h22, 1'b0, GL, 1'b1);
        wr(17'h00202, 8'h33, 1'b1, 4, 1'b0);
        repeat (WIN + 5) @(negedge clk);
        check(busy == 1'b0, "R4 glitch/oe no page", 128'(busy), 128'd0);
        wr(17'h00203, 8'h44, 1'b1, GL + 1, 1'b1);
        model_wr(17'h00203, 8'h44);
        window_check("R4 min width");
        check_payload("R1 R4 R5 single byte");
        finish_prog();

        // R2 + R3: last falling edge picks address, first rising edge picks data
        @(negedge clk); addr = 17'h1FF00; din = 8'hA5; we_n = 1'b0;
        repeat (3) @(negedge clk);
        addr = 17'h0AB7C; ce_n = 1'b0;
        repeat (4) @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk); din = 8'h5A;
        @(negedge clk); we_n = 1'b1;
        model_wr(17'h0AB7C, 8'hA5);
        repeat (WIN + 2) @(negedge clk);
        check(busy == 1'b1, "R2 page closed", 128'(busy), 128'd1);
        check_payload("R2 R3 edge capture");
        finish_prog();

        // R6 + R7: random pages, offsets, orders and overwrites
        for (int p = 0; p < 6; p++) begin
            logic [9:0] pg = 10'($urandom % 1024);
            int n = 1 + int'($urandom % 12);
            logic [6:0] last_ofs = '0;
            for (int j = 0; j < n; j++) begin
                logic [6:0] ofs = 7'($urandom % 128);
                if (j > 0 && ($urandom % 4) == 0) ofs = last_ofs;
                last_ofs = ofs;
                a = {pg, ofs};
                d = 8'($urandom);
                wr(a, d, 1'($urandom % 2), 3 + int'($urandom % 4), 1'b1);
                model_wr(a, d);
            end
            window_check("R7 random page");
            check_payload("R6 random page");
            // R9: a write during programming is ignored
            wr({pg, 7'(last_ofs + 7'd1)}, 8'hEE, 1'b0, 4, 1'b1);
            check_payload("R9 write while busy");
            finish_prog();
            repeat (WIN + 5) @(negedge clk);
            check(busy == 1'b0, "R9 no page from busy write", 128'(busy), 128'd0);
        end

        // R8: foreign-page byte closes the page and is dropped
        wr(17'h12301, 8'h01, 1'b0, 4, 1'b1); model_wr(17'h12301, 8'h01);
        wr(17'h12340, 8'h02, 1'b1, 4, 1'b1); model_wr(17'h12340, 8'h02);
        wr(17'h1237F, 8'h03, 1'b0, 4, 1'b1); model_wr(17'h1237F, 8'h03);
        wr(17'h12381, 8'h04, 1'b0, 4, 1'b1);
        check(busy == 1'b1, "R8 immediate close", 128'(busy), 128'd1);
        check_payload("R8 foreign byte dropped");
        finish_prog();
        repeat (WIN + 5) @(negedge clk);
        check(busy == 1'b0, "R8 no new page", 128'(busy), 128'd0);

        // R5: supply drop inside a load blocks the next byte
        wr(17'h04410, 8'h77, 1'b0, 4, 1'b1); model_wr(17'h04410, 8'h77);
        @(negedge clk); pwr_ok = 1'b0;
        wr(17'h04411, 8'h88, 1'b1, 4, 1'b1);
        @(negedge clk); pwr_ok = 1'b1;
        repeat (WIN) @(negedge clk);
        check(busy == 1'b1, "R5 page closed", 128'(busy), 128'd1);
        check_payload("R5 supply low byte dropped");
        finish_prog();

        summary();
    end
endmodule